// File: doc/BRIEF.md
# Piezo Buzzer Tone Generator

This block drives a piezo buzzer from a 32768 Hz clock. Software programs it through four byte-wide registers: a clock-gate register, a control register (run bit, mode, duration), a pitch register and a level register. The output is a rectangular wave whose period comes from an eight-entry pitch table and whose high time shrinks as the level code rises, so a larger level code gives a quieter tone.

Three modes share one run bit. In continuous mode the tone plays until software clears the bit. In one-shot mode, writing the bit to 1 starts a burst of fixed length, after which the block clears the bit and drives the output low. In fade mode the burst also has a fixed length, and the level steps one code quieter at each eighth of it. The `busy` output shows the run bit, so software can poll for the end of a burst. When the gate bit is 0, the output is held low and all timing is frozen.

Top module: `piezo_tone`

## Requirements
- R1: After reset every register reads 0. Reads are registered: the data for `reg_addr` appears one cycle later. The map is: address 0 holds the gate in bit 0. Address 1 holds run in bit 0, mode in bits 2:1 and duration select in bits 4:3. Address 2 holds pitch in bits 2:0. Address 3 holds level in bits 2:0. Unused bits read 0.
- R2: Pitch codes 0..7 give tone periods of 8, 10, 12, 14, 16, 20, 24 and 28 clock cycles.
- R3: For period P and level code L, the high time is P/2 − floor((P/2)·L/8), with a minimum of 1. Code 0 gives 50 % duty.
- R4: Mode 0 (continuous) and mode 3 (treated as continuous) keep playing until software writes run = 0.
- R5: Mode 1 (one-shot) plays for 512·2^T cycles, where T is the duration select. It then clears the run bit and holds the output low.
- R6: Mode 2 (fade) has the same duration as R5. The level starts at the programmed code and rises by 1 (saturating at 7) every 64·2^T cycles. At the end the run bit clears.
- R7: While the gate is 0 the output is low. The phase and duration counters are frozen and resume when the gate returns to 1.
- R8: Writing run = 0 stops the tone on the next cycle. Writing run = 1 during a timed run does not restart it.
- R9: A write of run = 1 in the same cycle that a timed run expires restarts it with a full new duration from phase 0.
- R10: `busy` equals the run bit, and the output is high only while `busy` is 1.
- R11: A run starts with the output high in its first cycle. Cycle i of the run is high when (i mod P) is less than the high time in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz generator clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| tone_out | output | 1 | Buzzer drive, registered |
| busy | output | 1 | Run bit: tone active |

## Verification
Two actions can fall in the same cycle: the sequencer's own clearing of the run bit at the end of a timed burst, and a software write to the control register. The bench counts cycles from the start of a burst and places a run = 1 write exactly on the expiry edge. It then checks that `busy` never drops and that the output pattern restarts from phase 0 and lasts a full new duration. A second case switches the gate off and on again in the middle of a one-shot burst. The bench checks that the burst end moves out by exactly the number of gated cycles.

// File: rtl/buzz_pkg.sv
package buzz_pkg;
  localparam int CODE_W  = 3;
  localparam int PHASE_W = 5;
  localparam int ADDR_GATE  = 0;
  localparam int ADDR_CTRL  = 1;
  localparam int ADDR_PITCH = 2;
  localparam int ADDR_LEVEL = 3;

  typedef enum logic [1:0] {
    MODE_CONT = 2'd0,
    MODE_ONCE = 2'd1,
    MODE_FADE = 2'd2,
    MODE_RSVD = 2'd3
  } mode_e;

  // Tone period in clock cycles for a pitch code.
  function automatic logic [PHASE_W-1:0] tone_period(input logic [CODE_W-1:0] code);
    logic [PHASE_W-1:0] p;
    if (code[2]) p = PHASE_W'(16) + {1'b0, code[1:0], 2'b00};
    else         p = PHASE_W'(8)  + {2'b00, code[1:0], 1'b0};
    return p;
  endfunction

  // High time: half period reduced in eighths by the level code, floor 1.
  function automatic logic [PHASE_W-1:0] tone_high(input logic [PHASE_W-1:0] period,
                                                   input logic [CODE_W-1:0] lvl);
    logic [7:0] half;
    logic [7:0] prod;
    logic [7:0] h;
    half = {3'b000, period[PHASE_W-1:1]};
    prod = half * {5'b00000, lvl};
    h    = half - {3'b000, prod[7:3]};
    if (h == 8'd0) h = 8'd1;
    return h[PHASE_W-1:0];
  endfunction
endpackage

// File: rtl/buzz_regs.sv
module buzz_regs
  import buzz_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              run_state,
  output logic              gate_on,
  output mode_e             mode,
  output logic [1:0]        tsel,
  output logic [CODE_W-1:0] pitch,
  output logic [CODE_W-1:0] level,
  output logic              ctrl_wr,
  output logic              ctrl_run,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] rd_d;

  assign ctrl_wr  = wr_en && (addr == ADDR_W'(ADDR_CTRL));
  assign ctrl_run = wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_on <= 1'b0;
      mode    <= MODE_CONT;
      tsel    <= '0;
      pitch   <= '0;
      level   <= '0;
    end else if (wr_en) begin
      case (addr)
        ADDR_W'(ADDR_GATE):  gate_on <= wdata[0];
        ADDR_W'(ADDR_CTRL): begin
          mode <= mode_e'(wdata[2:1]);
          tsel <= wdata[4:3];
        end
        ADDR_W'(ADDR_PITCH): pitch <= wdata[CODE_W-1:0];
        default:             level <= wdata[CODE_W-1:0];
      endcase
    end
  end

  always_comb begin
    rd_d = '0;
    case (addr)
      ADDR_W'(ADDR_GATE):  rd_d[0] = gate_on;
      ADDR_W'(ADDR_CTRL):  rd_d[4:0] = {tsel, mode, run_state};
      ADDR_W'(ADDR_PITCH): rd_d[CODE_W-1:0] = pitch;
      default:             rd_d[CODE_W-1:0] = level;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_d;
  end
endmodule

// File: rtl/buzz_seq.sv
module buzz_seq
  import buzz_pkg::*;
#(
  parameter int BASE_TICKS = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gate_on,
  input  mode_e             mode,
  input  logic [1:0]        tsel,
  input  logic [CODE_W-1:0] level,
  input  logic              ctrl_wr,
  input  logic              ctrl_run,
  output logic              run_q,
  output logic              run_nxt,
  output logic              restart,
  output logic [CODE_W-1:0] lvl_q
);
  localparam int TW = $clog2(BASE_TICKS) + 4;
  localparam logic [CODE_W-1:0] LVL_MAX = '1;

  logic [TW-1:0] total, step, tcnt, scnt;
  logic timed, advance, expire, start;

  always_comb begin
    total   = TW'(BASE_TICKS) << tsel;
    step    = total >> 3;
    timed   = (mode == MODE_ONCE) || (mode == MODE_FADE);
    advance = run_q && gate_on && timed;
    expire  = advance && (tcnt >= total - 1'b1);
    start   = ctrl_wr && ctrl_run && (!run_q || expire);
    if (start)                     run_nxt = 1'b1;
    else if (ctrl_wr && !ctrl_run) run_nxt = 1'b0;
    else if (expire)               run_nxt = 1'b0;
    else                           run_nxt = run_q;
  end

  assign restart = start;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      tcnt  <= '0;
      scnt  <= '0;
      lvl_q <= '0;
    end else begin
      run_q <= run_nxt;
      if (start) begin
        tcnt  <= '0;
        scnt  <= '0;
        lvl_q <= level;
      end else if (advance) begin
        tcnt <= tcnt + 1'b1;
        if (scnt >= step - 1'b1) begin
          scnt <= '0;
          if (lvl_q != LVL_MAX) lvl_q <= lvl_q + 1'b1;
        end else begin
          scnt <= scnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/buzz_tone.sv
module buzz_tone
  import buzz_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              gate_on,
  input  logic              play_nxt,
  input  logic              restart,
  input  logic [CODE_W-1:0] pitch,
  input  logic [CODE_W-1:0] level,
  output logic              tone_out
);
  logic [PHASE_W-1:0] ph, ph_cur, period, high;

  always_comb begin
    period = tone_period(pitch);
    high   = tone_high(period, level);
    ph_cur = restart ? '0 : ph;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= '0;
      tone_out <= 1'b0;
    end else if (!gate_on) begin
      tone_out <= 1'b0;
      if (restart) ph <= '0;
    end else if (!play_nxt) begin
      ph       <= '0;
      tone_out <= 1'b0;
    end else begin
      tone_out <= (ph_cur < high);
      ph       <= (ph_cur >= period - 1'b1) ? '0 : ph_cur + 1'b1;
    end
  end
endmodule

// File: rtl/piezo_tone.sv
module piezo_tone
  import buzz_pkg::*;
#(
  parameter int BASE_TICKS = 512,
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              tone_out,
  output logic              busy
);
  logic              gate_on, ctrl_wr, ctrl_run, run_nxt, restart;
  mode_e             mode;
  logic [1:0]        tsel;
  logic [CODE_W-1:0] pitch, level, fade_lvl, eff_lvl;

  buzz_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .run_state(busy), .gate_on(gate_on), .mode(mode), .tsel(tsel),
    .pitch(pitch), .level(level), .ctrl_wr(ctrl_wr), .ctrl_run(ctrl_run),
    .rdata(reg_rdata)
  );

  buzz_seq #(.BASE_TICKS(BASE_TICKS)) u_seq (
    .clk(clk), .rst(rst), .gate_on(gate_on), .mode(mode), .tsel(tsel),
    .level(level), .ctrl_wr(ctrl_wr), .ctrl_run(ctrl_run), .run_q(busy),
    .run_nxt(run_nxt), .restart(restart), .lvl_q(fade_lvl)
  );

  assign eff_lvl = (mode == MODE_FADE) ? fade_lvl : level;

  buzz_tone u_tone (
    .clk(clk), .rst(rst), .gate_on(gate_on), .play_nxt(run_nxt),
    .restart(restart), .pitch(pitch), .level(eff_lvl), .tone_out(tone_out)
  );
endmodule

// File: rtl/piezo_tone_chk.sv
module piezo_tone_chk #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              tone_out,
  input logic              busy,
  input logic              gate_on,
  input logic [1:0]        mode,
  input logic [2:0]        fade_lvl
);
  logic ctl_wr;
  assign ctl_wr = reg_wr && (reg_addr == ADDR_W'(1));

  a_r1_rdata_pad: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[DATA_W-1:5] == '0);

  a_r7_gate_mutes: assert property (@(posedge clk) disable iff (rst)
    !gate_on |=> !tone_out);

  a_r10_out_needs_busy: assert property (@(posedge clk) disable iff (rst)
    tone_out |-> busy);

  a_r11_start_high: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && $past(gate_on)) |-> tone_out);

  a_r4_untimed_holds: assert property (@(posedge clk) disable iff (rst)
    (busy && (mode == 2'd0 || mode == 2'd3) && !ctl_wr) |=> busy);

  a_r5_self_clear_timed: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(mode == 2'd1 || mode == 2'd2) || $past(ctl_wr)));

  a_r6_fade_monotonic: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && mode == 2'd2 && !$past(ctl_wr)) |-> fade_lvl >= $past(fade_lvl));
endmodule

bind piezo_tone piezo_tone_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .tone_out(tone_out), .busy(busy),
  .gate_on(gate_on), .mode(mode), .fade_lvl(fade_lvl)
);

// File: tb/piezo_tone_tb_top.sv
module piezo_tone_tb_top;
  localparam int BASE = 512;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tone_out, busy;
  int nchk = 0;
  int nerr = 0;
  int cycles = 0;

  piezo_tone #(.BASE_TICKS(BASE)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tone_out(tone_out), .busy(busy)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      nerr = nerr + 1;
      nchk = nchk + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  function automatic int bper(int c);
    return (c < 4) ? 8 + 2 * c : 16 + 4 * (c - 4);
  endfunction
  function automatic int bhigh(int p, int l);
    int h;
    h = p / 2 - ((p / 2) * l) / 8;
    return (h < 1) ? 1 : h;
  endfunction
  function automatic int blvl(int d, int i, int stp, bit fade);
    int v;
    if (!fade || i == 0) return d;
    v = d + (i - 1) / stp;
    return (v > 7) ? 7 : v;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    reg_wr = 1'b1; reg_addr = 2'(a); reg_wdata = 8'(d);
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    reg_addr = 2'(a);
    step();
    v = int'(reg_rdata);
  endtask

  // Called at sample i=0 of a run; compares every cycle of the run.
  task automatic observe(int pc, int d, int ncyc, bit fade, bit timed, string tag);
    int p, stp, mism, fa, fe;
    p = bper(pc); stp = ncyc / 8; mism = 0; fa = 0; fe = 0;
    for (int i = 0; i < ncyc; i++) begin
      int e;
      if (i > 0) step();
      e = ((i % p) < bhigh(p, blvl(d, i, stp, fade))) ? 1 : 0;
      if (int'(tone_out) != e || busy !== 1'b1) begin
        if (mism == 0) begin fa = int'(tone_out); fe = e; end
        mism++;
      end
    end
    check(mism == 0, {tag, " pattern"}, fa, fe);
    if (timed) begin
      step();
      check(busy == 1'b0 && tone_out == 1'b0, {tag, " end low"}, int'(busy) + int'(tone_out), 0);
    end
  endtask

  initial begin
    int v;
    repeat (5) step();
    rst = 1'b0;
    step();
    // R1 reset state and readback
    check(tone_out == 1'b0 && busy == 1'b0, "R1 outputs idle", int'(tone_out), 0);
    for (int a = 0; a < 4; a++) begin
      rd(a, v);
      check(v == 0, "R1 reset read", v, 0);
    end
    wr(2, 8'hFF); rd(2, v); check(v == 7, "R1 pitch field", v, 7);
    wr(3, 8'hFF); rd(3, v); check(v == 7, "R1 level field", v, 7);
    wr(1, 8'hFE); rd(1, v); check(v == 8'h1E, "R1 ctrl field", v, 8'h1E);
    wr(1, 8'h00);
    wr(0, 8'hFF); rd(0, v); check(v == 1, "R1 gate field", v, 1);

    // R2 R3 R11 sweep of pitch and level in continuous mode, R8 stop
    for (int pc = 0; pc < 8; pc++) begin
      for (int d = 0; d < 8; d++) begin
        wr(2, pc); wr(3, d);
        wr(1, 8'h01);
        observe(pc, d, 2 * bper(pc) + 3, 1'b0, 1'b0, $sformatf("R2 R3 p%0d d%0d", pc, d));
        wr(1, 8'h00);
        check(busy == 1'b0 && tone_out == 1'b0, "R8 stop on write 0", int'(busy), 0);
      end
    end

    // R4 reserved mode 3 plays past any timed length
    wr(2, 3); wr(3, 2);
    wr(1, 8'h07);
    observe(3, 2, 700, 1'b0, 1'b0, "R4 mode3 continuous");
    wr(1, 8'h00);

    // R5 one-shot for each duration
    for (int t = 0; t < 4; t++) begin
      wr(2, t + 1); wr(3, t);
      wr(1, (t << 3) | 8'h03);
      observe(t + 1, t, BASE << t, 1'b0, 1'b1, $sformatf("R5 oneshot t%0d", t));
      rd(1, v);
      check(v == ((t << 3) | 2), "R5 run bit cleared", v, (t << 3) | 2);
    end

    // R6 fade for each duration, plus a saturating case
    for (int t = 0; t < 5; t++) begin
      int ts, d;
      ts = (t < 4) ? t : 1;
      d  = (t < 4) ? 0 : 5;
      wr(2, 7 - t); wr(3, d);
      wr(1, (ts << 3) | 8'h05);
      observe(7 - t, d, BASE << ts, 1'b1, 1'b1, $sformatf("R6 fade t%0d d%0d", ts, d));
    end

    // R8 retrigger ignored mid-run
    begin
      int i;
      wr(2, 0); wr(3, 0);
      wr(1, 8'h03);
      repeat (99) step();
      wr(1, 8'h03);
      i = 100;
      while (busy && i < 5000) begin step(); i++; end
      check(i == BASE, "R8 retrigger ignored", i, BASE);
    end

    // R9 write run=1 on the expiry cycle restarts
    wr(1, 8'h03);
    repeat (BASE - 1) step();
    check(busy == 1'b1, "R9 still busy before expiry", int'(busy), 1);
    wr(1, 8'h03);
    observe(0, 0, BASE, 1'b0, 1'b1, "R9 restart at expiry");

    // R7 gate freezes and mutes mid one-shot
    begin
      int adv, c, bad, mute_bad;
      bit gm, gp, gn;
      wr(1, 8'h03);
      adv = 0; c = 0; bad = 0; mute_bad = 0; gm = 1'b1; gp = 1'b1;
      while (c < 3000) begin
        if (busy != (adv < BASE)) bad++;
        if (!gp && tone_out) mute_bad++;
        if (!busy && adv >= BASE) break;
        if (c == 100)      begin reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'd0; gn = 1'b0; end
        else if (c == 160) begin reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'd1; gn = 1'b1; end
        else               begin gn = gm; end
        step();
        reg_wr = 1'b0;
        gp = gm;
        if (gm) adv++;
        gm = gn;
        c++;
      end
      check(bad == 0, "R7 busy tracks ungated cycles", bad, 0);
      check(mute_bad == 0, "R7 output low while gated", mute_bad, 0);
      check(c == BASE + 60, "R7 end delayed by gated cycles", c, BASE + 60);
    end

    // R10 idle after all runs
    step();
    check(busy == 1'b0 && tone_out == 1'b0, "R10 idle low", int'(tone_out), 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule